// File: doc/BRIEF.md
# Completion Ring Posting Engine

This block owns one circular completion ring kept in host memory. Each finished command arrives as a pending completion carrying a command identifier, a submission queue identifier, that submission queue's current head and a 15-bit status code. The block turns it into a 16-byte ring entry and issues one memory write for it, at the entry slot addressed by the tail pointer. The host consumes entries and returns the freed slots by writing a new head value through a doorbell input.

A phase bit tells the host which entries are new, so it does not have to read the tail. The phase bit starts at one. It is stored in bit 0 of every posted status word and inverts each time the tail wraps to slot zero. When the slot after the tail is the head, the ring is full and posting stalls with backpressure. When a run of postings ends, the block raises a one-cycle interrupt request, but only if interrupts are enabled for the queue. The queue size, base address, entry size and interrupt enable are run-time settings, latched by a create pulse.

Top module: `cq_post_engine`

## Requirements
- R1: After synchronous reset, head and tail are 0 and phase is 1. The first entry presented therefore addresses base 0 with status bit 0 set, ring_not_empty is 0 and irq is 0.
- R2: mem_addr equals the latched base plus tail multiplied by 2 to the power of the latched entry-size exponent.
- R3: mem_data[127:112] is {status code, phase}, with the phase in bit 112. mem_data[111:96] is the command id, [95:80] the submission queue id, [79:64] the submission queue head, and [63:0] is zero.
- R4: An entry is posted only in a cycle where mem_valid and mem_ready are both high. cpl_ready equals mem_ready while the ring is not full. The tail advances by exactly one per posted entry and holds while the write is stalled.
- R5: When the incremented tail equals the queue size, the tail becomes 0 and the phase inverts, so the entries of the next lap carry status bit 0 inverted.
- R6: ring_full is high when (tail + 1) modulo size equals head. While the ring is full, mem_valid and cpl_ready are low and the tail does not move.
- R7: A doorbell with db_head below the queue size loads the head. A doorbell with db_head at or above the size is ignored.
- R8: ring_not_empty is high exactly when tail differs from head.
- R9: irq pulses high for one cycle, two cycles after the last posting cycle of a run (a run ends at the first cycle with no posting), and only when the latched interrupt enable is 1.
- R10: A cfg_create pulse latches cfg_base, cfg_size, cfg_esz_log2 and cfg_irq_en, and sets head and tail to 0 and phase to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_create | input | 1 | Create pulse: latch configuration, reset pointers |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_size | input | QPTR_W+1 | Number of ring slots |
| cfg_esz_log2 | input | ESZ_W | Entry size exponent (bytes = 2^value) |
| cfg_irq_en | input | 1 | Interrupt enable for the queue |
| cpl_valid | input | 1 | Pending completion present |
| cpl_ready | output | 1 | Completion taken this cycle when valid |
| cpl_cid | input | 16 | Command identifier |
| cpl_sqid | input | 16 | Submission queue identifier |
| cpl_sqhd | input | 16 | Submission queue head |
| cpl_code | input | 15 | Status code |
| db_valid | input | 1 | Host head doorbell write |
| db_head | input | QPTR_W | New head value |
| mem_valid | output | 1 | Entry write request |
| mem_ready | input | 1 | Memory accepts write |
| mem_addr | output | ADDR_W | Entry write address |
| mem_data | output | 128 | Formatted entry |
| ring_full | output | 1 | Ring has no free slot |
| ring_not_empty | output | 1 | Tail differs from head |
| irq | output | 1 | Interrupt request pulse |

## Verification
A tail off by one shows on mem_addr at the next presented entry, and a missed phase flip shows in status bit 0 of the first entry of the next lap. A wrong head or a wrong full term shows within a cycle: mem_valid is raised into a full ring, or a free ring stalls and cpl_ready stays low. The bench follows these pointers in its own model and compares every port in every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/cq_post_pkg.sv
package cq_post_pkg;

   localparam int ENTRY_BITS = 128;
   localparam int CODE_W     = 15;
   localparam int FIELD_W    = 16;

   typedef struct packed {
      logic [CODE_W-1:0]  code;
      logic [FIELD_W-1:0] cid;
      logic [FIELD_W-1:0] sqid;
      logic [FIELD_W-1:0] sqhd;
   } cq_cpl_t;

   // upper half holds status word, id fields; lower half is the unused result area
   function automatic logic [ENTRY_BITS-1:0] pack_entry(input cq_cpl_t c, input logic ph);
      pack_entry = {c.code, ph, c.cid, c.sqid, c.sqhd, 64'h0};
   endfunction

endpackage

// File: rtl/cq_ring_ptr.sv
module cq_ring_ptr #(
   parameter int QPTR_W = 4,
   parameter int SZ_W   = QPTR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              create,
   input  logic [SZ_W-1:0]   size_in,
   input  logic              adv,
   input  logic              db_valid,
   input  logic [QPTR_W-1:0] db_head,
   output logic [QPTR_W-1:0] tail,
   output logic [QPTR_W-1:0] head,
   output logic              phase,
   output logic [SZ_W-1:0]   size_q,
   output logic              full
);
   localparam logic [SZ_W-1:0] RST_SIZE = SZ_W'(1) << QPTR_W;

   logic [SZ_W-1:0]   tail_inc;
   logic              wrap;
   logic [QPTR_W-1:0] tail_nxt;
   logic              db_ok;

   always_comb begin
      tail_inc = {1'b0, tail} + SZ_W'(1);
      wrap     = (tail_inc == size_q);
      tail_nxt = wrap ? '0 : tail_inc[QPTR_W-1:0];
      full     = (tail_nxt == head);
      db_ok    = db_valid && ({1'b0, db_head} < size_q);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tail   <= '0;
         head   <= '0;
         phase  <= 1'b1;
         size_q <= RST_SIZE;
      end else if (create) begin
         tail   <= '0;
         head   <= '0;
         phase  <= 1'b1;
         size_q <= size_in;
      end else begin
         if (adv) begin
            tail <= tail_nxt;
            if (wrap) phase <= ~phase;
         end
         if (db_ok) head <= db_head;
      end
   end
endmodule

// File: rtl/cq_entry_fmt.sv
module cq_entry_fmt
   import cq_post_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int QPTR_W = 4,
   parameter int ESZ_W  = 3
) (
   input  logic [ADDR_W-1:0]     base,
   input  logic [QPTR_W-1:0]     tail,
   input  logic [ESZ_W-1:0]      esz_log2,
   input  logic                  phase,
   input  cq_cpl_t               cpl,
   output logic [ADDR_W-1:0]     addr,
   output logic [ENTRY_BITS-1:0] data
);
   always_comb begin
      addr = base + (ADDR_W'(tail) << esz_log2);
      data = pack_entry(cpl, phase);
   end
endmodule

// File: rtl/cq_irq_gen.sv
module cq_irq_gen (
   input  logic clk,
   input  logic rst,
   input  logic enable,
   input  logic fire,
   output logic irq
);
   logic post_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         post_q <= 1'b0;
         irq    <= 1'b0;
      end else begin
         post_q <= fire;
         irq    <= enable && post_q && !fire;
      end
   end
endmodule

// File: rtl/cq_post_engine.sv
module cq_post_engine
   import cq_post_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int QPTR_W         = 4,
   parameter int ESZ_W          = 3,
   parameter int FIXED_ESZ_LOG2 = 0,
   parameter int RST_ESZ_LOG2   = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cfg_create,
   input  logic [ADDR_W-1:0]     cfg_base,
   input  logic [QPTR_W:0]       cfg_size,
   input  logic [ESZ_W-1:0]      cfg_esz_log2,
   input  logic                  cfg_irq_en,
   input  logic                  cpl_valid,
   output logic                  cpl_ready,
   input  logic [15:0]           cpl_cid,
   input  logic [15:0]           cpl_sqid,
   input  logic [15:0]           cpl_sqhd,
   input  logic [14:0]           cpl_code,
   input  logic                  db_valid,
   input  logic [QPTR_W-1:0]     db_head,
   output logic                  mem_valid,
   input  logic                  mem_ready,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [ENTRY_BITS-1:0] mem_data,
   output logic                  ring_full,
   output logic                  ring_not_empty,
   output logic                  irq
);
   localparam int SZ_W = QPTR_W + 1;

   if (QPTR_W < 1 || QPTR_W > 16) begin : g_bad_qptr
      $error("QPTR_W out of range");
   end
   if (ESZ_W < 1 || ADDR_W < 8) begin : g_bad_width
      $error("ESZ_W or ADDR_W too small");
   end
   if (FIXED_ESZ_LOG2 >= (1 << ESZ_W) || RST_ESZ_LOG2 >= (1 << ESZ_W)) begin : g_bad_esz
      $error("entry size exponent does not fit ESZ_W");
   end

   logic [QPTR_W-1:0] tail;
   logic [QPTR_W-1:0] head;
   logic              phase;
   logic [SZ_W-1:0]   size_q;
   logic [ADDR_W-1:0] base_q;
   logic [ESZ_W-1:0]  esz_cfg_q;
   logic [ESZ_W-1:0]  esz_use;
   logic              irq_en_q;
   logic              fire;
   cq_cpl_t           cpl;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q    <= '0;
         esz_cfg_q <= ESZ_W'(RST_ESZ_LOG2);
         irq_en_q  <= 1'b0;
      end else if (cfg_create) begin
         base_q    <= cfg_base;
         esz_cfg_q <= cfg_esz_log2;
         irq_en_q  <= cfg_irq_en;
      end
   end

   if (FIXED_ESZ_LOG2 > 0) begin : g_esz_fixed
      logic unused_esz;
      assign unused_esz = ^esz_cfg_q;
      assign esz_use    = ESZ_W'(FIXED_ESZ_LOG2);
   end else begin : g_esz_cfg
      assign esz_use = esz_cfg_q;
   end

   assign cpl       = '{code: cpl_code, cid: cpl_cid, sqid: cpl_sqid, sqhd: cpl_sqhd};
   assign mem_valid = cpl_valid && !ring_full;
   assign cpl_ready = mem_ready && !ring_full;
   assign fire      = mem_valid && mem_ready;
   assign ring_not_empty = (tail != head);

   cq_ring_ptr #(.QPTR_W(QPTR_W), .SZ_W(SZ_W)) u_ring (
      .clk      (clk),
      .rst      (rst),
      .create   (cfg_create),
      .size_in  (cfg_size),
      .adv      (fire),
      .db_valid (db_valid),
      .db_head  (db_head),
      .tail     (tail),
      .head     (head),
      .phase    (phase),
      .size_q   (size_q),
      .full     (ring_full)
   );

   cq_entry_fmt #(.ADDR_W(ADDR_W), .QPTR_W(QPTR_W), .ESZ_W(ESZ_W)) u_fmt (
      .base     (base_q),
      .tail     (tail),
      .esz_log2 (esz_use),
      .phase    (phase),
      .cpl      (cpl),
      .addr     (mem_addr),
      .data     (mem_data)
   );

   cq_irq_gen u_irq (
      .clk    (clk),
      .rst    (rst),
      .enable (irq_en_q),
      .fire   (fire),
      .irq    (irq)
   );
endmodule

// File: rtl/cq_post_engine_chk.sv
module cq_post_engine_chk #(
   parameter int QPTR_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_create,
   input logic              db_valid,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              ring_full,
   input logic              irq,
   input logic              irq_en_q,
   input logic              phase,
   input logic [QPTR_W-1:0] tail,
   input logic [QPTR_W-1:0] head,
   input logic [QPTR_W:0]   size_q
);
   AST_POST_ADVANCES_ONE: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && mem_ready && !cfg_create) |=>
         ((tail == $past(tail) + 1'b1) && (phase == $past(phase))) ||
         ((tail == '0) && (phase != $past(phase)))); // R4

   AST_STALL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && !mem_ready && !cfg_create) |=> $stable(tail)); // R4

   AST_FULL_FREEZES_TAIL: assert property (@(posedge clk) disable iff (rst)
      (ring_full && !cfg_create) |=> $stable(tail) && $stable(phase)); // R6

   AST_TAIL_IN_RING: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, tail} < size_q)); // R5

   AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, head} < size_q)); // R7

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      irq |=> !irq); // R9

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      !irq_en_q |=> !irq); // R9

   AST_NO_IRQ_WHILE_POSTING: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && mem_ready) |=> !irq); // R9

   logic unused_db;
   assign unused_db = db_valid;
endmodule

bind cq_post_engine cq_post_engine_chk #(.QPTR_W(QPTR_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cfg_create (cfg_create),
   .db_valid   (db_valid),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .ring_full  (ring_full),
   .irq        (irq),
   .irq_en_q   (irq_en_q),
   .phase      (phase),
   .tail       (tail),
   .head       (head),
   .size_q     (size_q)
);

// File: tb/cq_post_engine_bench.sv
module cq_post_engine_bench;
   localparam int AW = 32;
   localparam int QW = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           cfg_create = 1'b0;
   logic [AW-1:0]  cfg_base = '0;
   logic [QW:0]    cfg_size = '0;
   logic [2:0]     cfg_esz_log2 = '0;
   logic           cfg_irq_en = 1'b0;
   logic           cpl_valid = 1'b0;
   logic           cpl_ready;
   logic [15:0]    cpl_cid = '0, cpl_sqid = '0, cpl_sqhd = '0;
   logic [14:0]    cpl_code = '0;
   logic           db_valid = 1'b0;
   logic [QW-1:0]  db_head = '0;
   logic           mem_valid;
   logic           mem_ready = 1'b0;
   logic [AW-1:0]  mem_addr;
   logic [127:0]   mem_data;
   logic           ring_full, ring_not_empty, irq;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   // bench reference state
   int        m_tail = 0, m_head = 0, m_size = 16, m_esz = 4;
   bit        m_phase = 1'b1, m_en = 1'b0, m_post = 1'b0, m_irq = 1'b0;
   logic [AW-1:0] m_base = '0;

   cq_post_engine u_cq_post_engine (.*);

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_full();
      int nxt;
      nxt = (m_tail + 1 == m_size) ? 0 : m_tail + 1;
      return nxt == m_head;
   endfunction

   function automatic logic [AW-1:0] exp_addr();
      return m_base + (AW'(m_tail) << m_esz);
   endfunction

   function automatic logic [127:0] exp_data();
      return {cpl_code, m_phase, cpl_cid, cpl_sqid, cpl_sqhd, 64'h0};
   endfunction

   // one clock: randomize payload, compare every output, then advance the model
   task automatic cyc();
      bit f, fire;
      cpl_cid  = 16'($urandom);
      cpl_sqid = 16'($urandom);
      cpl_sqhd = 16'($urandom);
      cpl_code = 15'($urandom);
      #2;
      f    = exp_full();
      fire = cpl_valid && mem_ready && !f;
      chk("R6 ring_full", 128'(ring_full), 128'(f));
      chk("R6 mem_valid", 128'(mem_valid), 128'(cpl_valid && !f));
      chk("R4 cpl_ready", 128'(cpl_ready), 128'(mem_ready && !f));
      chk("R8 ring_not_empty", 128'(ring_not_empty), 128'(m_tail != m_head));
      chk("R2 mem_addr", 128'(mem_addr), 128'(exp_addr()));
      chk("R3 mem_data", mem_data, exp_data());
      chk("R9 irq", 128'(irq), 128'(m_irq));
      @(posedge clk);
      m_irq  = m_en && m_post && !fire;
      m_post = fire;
      if (cfg_create) begin
         m_base = cfg_base; m_size = int'(cfg_size); m_esz = int'(cfg_esz_log2);
         m_en = cfg_irq_en; m_tail = 0; m_head = 0; m_phase = 1'b1;
      end else begin
         if (fire) begin
            if (m_tail + 1 == m_size) begin m_tail = 0; m_phase = ~m_phase; end
            else m_tail = m_tail + 1;
         end
         if (db_valid && int'(db_head) < m_size) m_head = int'(db_head);
      end
      @(negedge clk);
   endtask

   task automatic create(input logic [AW-1:0] b, input int sz, input int e, input bit en);
      cfg_base = b; cfg_size = (QW+1)'(sz); cfg_esz_log2 = 3'(e); cfg_irq_en = en;
      cfg_create = 1'b1; cpl_valid = 1'b0; db_valid = 1'b0;
      cyc();
      cfg_create = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0C0FFEE5));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      cpl_valid = 1'b1; mem_ready = 1'b0;
      #2;
      chk("R1 addr at base 0 tail 0", 128'(mem_addr), 128'h0);
      chk("R1 phase starts at 1", 128'(mem_data[112]), 128'h1);
      chk("R1 not_empty low", 128'(ring_not_empty), 128'h0);
      chk("R1 irq low", 128'(irq), 128'h0);
      cyc();

      // R10: create latches configuration
      create(32'h1000, 4, 4, 1'b1);
      cpl_valid = 1'b1; mem_ready = 1'b0;
      #2;
      chk("R10 new base", 128'(mem_addr), 128'h1000);
      chk("R10 not full", 128'(ring_full), 128'h0);
      cyc();

      // fill: three postings make the 4-slot ring full
      mem_ready = 1'b1;
      repeat (3) cyc();
      #2;
      chk("R6 full after three posts", 128'(ring_full), 128'h1);
      chk("R6 no request when full", 128'(mem_valid), 128'h0);
      cyc();

      // R7: out-of-range doorbell ignored
      db_valid = 1'b1; db_head = 4'd7;
      cyc();
      db_valid = 1'b0;
      #2;
      chk("R7 bad doorbell ignored", 128'(ring_full), 128'h1);
      cyc();

      // legal doorbell frees slots, then wrap
      db_valid = 1'b1; db_head = 4'd2; cpl_valid = 1'b0;
      cyc();
      db_valid = 1'b0; cpl_valid = 1'b1;
      cyc();
      mem_ready = 1'b0;
      #2;
      chk("R5 phase inverted after wrap", 128'(mem_data[112]), 128'h0);
      chk("R5 tail back at slot 0", 128'(mem_addr), 128'h1000);
      cyc();
      cpl_valid = 1'b0;
      repeat (4) cyc();

      // random phase over several configurations
      for (int k = 0; k < 6; k++) begin
         create(AW'($urandom) & 32'hFFFF_F000, 2 + int'($urandom % 15),
                4 + int'($urandom % 3), bit'($urandom % 2));
         for (int i = 0; i < 700; i++) begin
            cpl_valid = ($urandom % 10) < 7;
            mem_ready = ($urandom % 10) < 6;
            db_valid  = ($urandom % 10) < 2;
            db_head   = ($urandom % 4 == 0) ? QW'($urandom)
                                            : QW'($urandom % m_size);
            cyc();
         end
         cpl_valid = 1'b0; db_valid = 1'b0;
         repeat (3) cyc();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule